// File: doc/BRIEF.md
# Color Matrix Coefficient Encoder

This block converts one entry of a color transform matrix into the 16-bit coefficient word that a color-space converter pipe consumes. The entry arrives as a 64-bit sign-magnitude value: the top bit is the sign and the low 63 bits are an unsigned magnitude with 32 fraction bits. A matrix loader presents one entry per cycle with a valid strobe, and one cycle later the encoded word appears, held steady until the next entry arrives.

Two output layouts are supported and chosen per entry by a format input. The default layout is a floating window. A 3-bit range code records which power-of-two band the magnitude falls in, and a 9-bit rounded mantissa holds the significant bits inside that band. This keeps nine bits of precision for small coefficients as well as large ones. The second layout is a plain fixed-point word with 3 integer bits and 12 fraction bits, rounded to nearest and saturated.

Top module: `coef_word_encoder`

## Requirements
- R1: Output bit 15 is a copy of input bit 63 in both formats. Input bits 62:0 are treated as the magnitude only.
- R2: In window format (fmt=0), a magnitude of 4.0 or more is first clamped to 4·2^32−1. Every such input therefore encodes as 0x6FF8, plus the sign bit.
- R3: In window format, bits 14:12 hold the range code. Magnitudes below 0.125 give code 3 with 12 fraction bits. Magnitudes in [0.125, 0.25) give code 2 with 11 bits, [0.25, 0.5) give code 1 with 10 bits, and [0.5, 1.0) give code 0 with 9 bits. Magnitudes in [1.0, 2.0) give code 7 with 8 bits, and 2.0 and above give code 6 with 7 bits. Codes 4 and 5 never appear.
- R4: In window format, bits 11:0 are formed from the clamped magnitude. It is shifted right by 29 minus the band's fraction bits, 4 is added, and the result is saturated at 0xFFF. Bits 2:0 of the output are always zero.
- R5: When rounding carries past the top of a band, the mantissa saturates inside the same band. For example, 2^29−1 encodes as 0x3FF8.
- R6: A coefficient of exactly 1.0 in window format encodes as 0x7800.
- R7: In fixed format (fmt=1), 2^19 is added to the magnitude. Output bits 14:12 are then bits 34:32 of the sum and output bits 11:0 are bits 31:20 of the sum. For example, 1.0 gives 0x1000 and 2^19 gives 0x0001.
- R8: In fixed format, a rounded magnitude of 8.0 or more saturates bits 14:0 to all ones (0x7FFF plus the sign).
- R9: out_valid is high in the cycle after a cycle in which in_valid was high, and low otherwise.
- R10: out_word changes only in the cycle after a valid input. While in_valid is low it holds its value, whatever is on in_coef and in_fmt.
- R11: A negative zero keeps its sign. It encodes as 0xB000 in window format and 0x8000 in fixed format.
- R12: While rst_n is low, and after it is released with no input yet, out_valid is 0 and out_word is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coefficient is present this cycle |
| in_coef | input | 64 | Sign-magnitude coefficient, magnitude with 32 fraction bits |
| in_fmt | input | 1 | 0 selects window format, 1 selects fixed S3.12 format |
| out_valid | output | 1 | Encoded word produced this cycle |
| out_word | output | 16 | Encoded coefficient word, held between inputs |

## Verification
The hardest case to reach is a magnitude a few LSBs below a band threshold. There, the +4 rounding would spill into the next band, and the mantissa must saturate rather than change the range code. Random 64-bit inputs almost never land in those few values. The stimulus therefore walks every threshold and places values at the threshold itself, one below it, and just below the rounding point, in both signs. Values at and above the clamp limits of both formats are also included. A behavioural model in the bench predicts every cycle, including idle cycles where the word must not move.

// File: rtl/coefenc_pkg.sv
package coefenc_pkg;

    localparam int IN_W   = 64;
    localparam int MAG_W  = IN_W - 1;
    localparam int FRAC_W = 32;
    localparam int OUT_W  = 16;
    localparam int CODE_W = 3;
    localparam int BODY_W = OUT_W - 1 - CODE_W;

    typedef enum logic {
        FMT_WINDOW = 1'b0,
        FMT_S312   = 1'b1
    } coef_fmt_e;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] word;
    } enc_state_t;

endpackage

// File: rtl/coefenc_window.sv
module coefenc_window #(
    parameter int FRAC_W    = 32,
    parameter int MAG_W     = 63,
    parameter int MANT_W    = 9,
    parameter int GUARD_W   = 3,
    parameter int NBANDS    = 6,
    parameter int TOP_FBITS = 12,
    parameter int TOP_CODE  = 3,
    parameter int LOW_EXP   = 3,
    parameter int CLAMP_W   = FRAC_W + 2
) (
    input  logic [MAG_W-1:0]           mag,
    output logic [2:0]                 code,
    output logic [MANT_W+GUARD_W-1:0]  body
);

    localparam int SAT_W    = MANT_W + GUARD_W;
    localparam int BASE_BIT = FRAC_W - LOW_EXP;
    localparam logic [CLAMP_W:0] RND_ADD = (CLAMP_W+1)'(1) << (GUARD_W - 1);
    localparam logic [CLAMP_W:0] SAT_MAX = {{(CLAMP_W+1-SAT_W){1'b0}}, {SAT_W{1'b1}}};

    logic [CLAMP_W-1:0] mag_c;
    logic [NBANDS-1:0]  below;
    logic [SAT_W-1:0]   band_val  [NBANDS];
    logic [2:0]         band_code [NBANDS];

    // clamp to just under the top of the widest band
    assign mag_c = (|mag[MAG_W-1:CLAMP_W]) ? {CLAMP_W{1'b1}} : mag[CLAMP_W-1:0];

    for (genvar b = 0; b < NBANDS; b++) begin : g_band
        localparam int SH = FRAC_W - (TOP_FBITS - b) - GUARD_W;
        localparam int TB = BASE_BIT + b;
        localparam logic [2:0] BCODE = 3'((TOP_CODE - b) & 7);

        logic [CLAMP_W-1:0] shifted;
        logic [CLAMP_W:0]   rounded;

        assign shifted      = mag_c >> SH;
        assign rounded      = {1'b0, shifted} + RND_ADD;
        assign band_val[b]  = (rounded > SAT_MAX) ? {SAT_W{1'b1}} : rounded[SAT_W-1:0];
        assign band_code[b] = BCODE;

        if (TB < CLAMP_W) begin : g_thr
            assign below[b] = ~|mag_c[CLAMP_W-1:TB];
        end else begin : g_last
            assign below[b] = 1'b1;
        end
    end

    // lowest band whose ceiling exceeds the magnitude wins
    always_comb begin
        code = band_code[NBANDS-1];
        body = band_val[NBANDS-1];
        for (int b = NBANDS - 2; b >= 0; b--) begin
            if (below[b]) begin
                code = band_code[b];
                body = band_val[b];
            end
        end
    end

endmodule

// File: rtl/coefenc_s312.sv
module coefenc_s312 #(
    parameter int FRAC_W   = 32,
    parameter int MAG_W    = 63,
    parameter int INT_W    = 3,
    parameter int OUT_FRAC = 12
) (
    input  logic [MAG_W-1:0]          mag,
    output logic [INT_W+OUT_FRAC-1:0] field
);

    localparam int SUM_W = MAG_W + 1;
    localparam int LIM_W = FRAC_W + INT_W;
    localparam int DROP  = FRAC_W - OUT_FRAC;
    localparam logic [SUM_W-1:0] RND_ADD = SUM_W'(1) << (DROP - 1);

    logic [SUM_W-1:0] sum;
    logic [LIM_W-1:0] lim;
    logic             unused_low;

    assign sum        = {1'b0, mag} + RND_ADD;
    assign lim        = (|sum[SUM_W-1:LIM_W]) ? {LIM_W{1'b1}} : sum[LIM_W-1:0];
    assign field      = lim[LIM_W-1:DROP];
    assign unused_low = ^lim[DROP-1:0];

endmodule

// File: rtl/coef_word_encoder.sv
module coef_word_encoder
    import coefenc_pkg::*;
#(
    parameter int MANT_W  = 9,
    parameter int GUARD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_coef,
    input  logic              in_fmt,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_word
);

    localparam int BODY_LEN = MANT_W + GUARD_W;
    localparam logic [BODY_LEN-1:0] BODY_MASK = {{MANT_W{1'b1}}, {GUARD_W{1'b0}}};

    enc_state_t st_d, st_q;

    logic                        sign_in;
    logic [MAG_W-1:0]            mag_in;
    logic [2:0]                  win_code;
    logic [BODY_LEN-1:0]         win_body;
    logic [CODE_W+BODY_W-1:0]    fix_field;

    assign sign_in = in_coef[IN_W-1];
    assign mag_in  = in_coef[MAG_W-1:0];

    coefenc_window #(
        .FRAC_W  (FRAC_W),
        .MAG_W   (MAG_W),
        .MANT_W  (MANT_W),
        .GUARD_W (GUARD_W)
    ) u_window (
        .mag  (mag_in),
        .code (win_code),
        .body (win_body)
    );

    coefenc_s312 #(
        .FRAC_W   (FRAC_W),
        .MAG_W    (MAG_W),
        .INT_W    (CODE_W),
        .OUT_FRAC (BODY_W)
    ) u_s312 (
        .mag   (mag_in),
        .field (fix_field)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (coef_fmt_e'(in_fmt) == FMT_S312) begin
                st_d.word = {sign_in, fix_field};
            end else begin
                st_d.word = {sign_in, win_code, win_body & BODY_MASK};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

endmodule

// File: rtl/coefenc_checker.sv
module coefenc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_coef,
    input logic        in_fmt,
    input logic        out_valid,
    input logic [15:0] out_word
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word)); // R10
    AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[15] == $past(in_coef[63])); // R1
    AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fmt) |=> out_word[2:0] == 3'b000); // R4
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fmt) |=> (out_word[14:12] != 3'd4 && out_word[14:12] != 3'd5)); // R3
    AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fmt && (|in_coef[62:34])) |=> out_word[14:0] == 15'h6FF8); // R2
    AST_FIX_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt && (|in_coef[62:35])) |=> out_word[14:0] == 15'h7FFF); // R8

endmodule

bind coef_word_encoder coefenc_checker u_coefenc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_coef   (in_coef),
    .in_fmt    (in_fmt),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/coef_word_encoder_bench.sv
module coef_word_encoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_coef = '0;
    logic        in_fmt = 1'b0;
    logic        out_valid;
    logic [15:0] out_word;

    int    n_total = 0;
    int    n_bad   = 0;
    bit    done    = 1'b0;
    string cur_tag = "R12";

    logic        exp_valid = 1'b0;
    logic [15:0] exp_word  = '0;

    localparam longint unsigned ONE = 64'h1_0000_0000;

    always #2 clk = ~clk;

    coef_word_encoder u_coef_word_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_coef   (in_coef),
        .in_fmt    (in_fmt),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    function automatic logic [15:0] model(logic [63:0] c, logic f);
        longint unsigned m;
        longint unsigned lim;
        longint unsigned mm;
        int fb;
        logic [15:0] w;
        m = {1'b0, c[62:0]};
        w = '0;
        w[15] = c[63];
        if (f) begin
            m = m + (64'd1 << 19);
            if (m >= (64'd1 << 35)) m = (64'd1 << 35) - 1;
            w[14:12] = 3'((m >> 32) & 7);
            w[11:0]  = 12'((m >> 20) & 64'hFFF);
        end else begin
            if (m >= 4 * ONE) m = 4 * ONE - 1;
            fb  = 12;
            lim = ONE >> 3;
            while (fb > 7 && m >= lim) begin
                fb  = fb - 1;
                lim = lim << 1;
            end
            mm = (m >> (29 - fb)) + 4;
            if (mm > 64'hFFF) mm = 64'hFFF;
            mm = mm & 64'hFF8;
            w[14:12] = 3'((fb - 9) & 7);
            w[11:0]  = 12'(mm);
        end
        return w;
    endfunction

    // reference model, registered like the output
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_word  <= '0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) exp_word <= model(in_coef, in_fmt);
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_total++;
            if (out_valid !== exp_valid || out_word !== exp_word) begin
                n_bad++;
                $display("FAIL %s cycle compare: valid=%b word=%h expected valid=%b word=%h",
                         cur_tag, out_valid, out_word, exp_valid, exp_word);
            end
        end
    end

    task automatic check_word(input logic [15:0] expw, input string tag);
        n_total++;
        if (out_word !== expw || out_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s directed: word=%h valid=%b expected word=%h valid=1",
                     tag, out_word, out_valid, expw);
        end
    endtask

    task automatic send(input logic [63:0] c, input logic f, input string tag);
        @(posedge clk);
        #1;
        cur_tag  = tag;
        in_valid = 1'b1;
        in_coef  = c;
        in_fmt   = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_coef  = {$urandom, $urandom};
            in_fmt   = 1'($urandom);
        end
    endtask

    task automatic send_chk(input logic [63:0] c, input logic f,
                            input logic [15:0] expw, input string tag);
        send(c, f, tag);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        check_word(expw, tag);
    endtask

    initial begin
        // R12: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_total++;
        if (out_valid !== 1'b0 || out_word !== 16'h0000) begin
            n_bad++;
            $display("FAIL R12 reset: valid=%b word=%h expected valid=0 word=0000",
                     out_valid, out_word);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);

        send_chk(ONE, 1'b0, 16'h7800, "R6");                       // R6 exactly 1.0
        send_chk(64'h8000_0000_0000_0000, 1'b0, 16'hB000, "R11");  // R11 neg zero window
        send_chk(64'h8000_0000_0000_0000, 1'b1, 16'h8000, "R11");  // R11 neg zero fixed
        send_chk(4 * ONE, 1'b0, 16'h6FF8, "R2");                   // R2 at clamp
        send_chk(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 16'h6FF8, "R2");   // R2 huge
        send_chk(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 16'hEFF8, "R1");   // R1 sign kept on clamp
        send_chk((ONE >> 3) - 1, 1'b0, 16'h3FF8, "R5");            // R5 spill at top of band
        send_chk(ONE >> 3, 1'b0, 16'h2800, "R3");                  // R3 0.125 -> code 2
        send_chk(ONE >> 2, 1'b0, 16'h1800, "R3");                  // R3 0.25 -> code 1
        send_chk(ONE >> 1, 1'b0, 16'h0800, "R3");                  // R3 0.5 -> code 0
        send_chk(2 * ONE, 1'b0, 16'h6800, "R3");                   // R3 2.0 -> code 6
        send_chk(64'd1 << 20, 1'b0, 16'h3008, "R4");               // R4 small value rounding
        send_chk(ONE, 1'b1, 16'h1000, "R7");                       // R7 fixed 1.0
        send_chk(64'd1 << 19, 1'b1, 16'h0001, "R7");               // R7 round up
        send_chk((64'd1 << 19) - 1, 1'b1, 16'h0000, "R7");         // R7 round down
        send_chk(8 * ONE - 1, 1'b1, 16'h7FFF, "R8");               // R8 rounds over
        send_chk(64'h8000_0010_0000_0000, 1'b1, 16'hFFFF, "R8");   // R8 huge negative

        // R10: long idle with toggling inputs, word must hold
        cur_tag = "R10";
        idle(8);

        // R9: back-to-back valids and gaps
        cur_tag = "R9";
        for (int i = 0; i < 6; i++) send({$urandom, $urandom}, 1'($urandom), "R9");
        idle(1);
        send(ONE, 1'b0, "R9");
        idle(2);

        // R3 R4 R5: walk every band edge in both signs
        for (int b = 0; b < 6; b++) begin
            longint unsigned t;
            t = (ONE >> 3) << b;
            for (int d = 0; d < 6; d++) begin
                longint unsigned v;
                case (d)
                    0: v = t;
                    1: v = t - 1;
                    2: v = t - (t >> 12);
                    3: v = t - (t >> 11);
                    4: v = t + (t >> 12);
                    default: v = t - (t >> 13);
                endcase
                send({1'b0, v[62:0]}, 1'b0, "R5");
                send({1'b1, v[62:0]}, 1'b0, "R1");
                send({1'b0, v[62:0]}, 1'b1, "R7");
            end
        end
        idle(2);

        // random mix across magnitudes, formats and gaps
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] r;
            int sh;
            sh = $urandom_range(0, 62);
            r  = {$urandom, $urandom};
            r[62:0] = r[62:0] >> sh;
            if ($urandom_range(0, 3) == 0) idle(1);
            send(r, 1'($urandom), "R4");
        end
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule